// File: doc/BRIEF.md
# Mode-Selectable Burst Address Sequencer

This block generates the four-beat address sequence for a burst access. It starts from one base address that is captured once. The caller then steps through the group of four words with a single control line and never presents the address again. Only the two lowest address bits move. The bits above them stay at their loaded value for the whole burst.

The beat position is held in a small state machine with four named states: `BEAT_0`, `BEAT_1`, `BEAT_2` and `BEAT_3`. A load returns the machine to `BEAT_0` from any state. An advance takes the transitions `BEAT_0 -> BEAT_1 -> BEAT_2 -> BEAT_3 -> BEAT_0`, and the last of these is the wrap back into the group. When the clock enable is inactive, every state keeps its value.

A static select input chooses how the beat number is combined with the loaded low bits:
- In sequential order the beat number is added to the low bits, modulo four.
- In interleaved order the beat number is XORed with the low bits.

Advancing depends only on the clock enable and the load/advance line. It does not depend on any chip-select or write qualifier, so the surrounding access controller can keep stepping through a burst whatever its other controls are doing.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until the first load, `cur_addr` is all zeros and the beat state is `BEAT_0`.
- R2: At a rising edge with `ce_n` low and `adv_nld` low, `base_addr` is captured and the beat returns to `BEAT_0`. From the following cycle `cur_addr` equals the captured `base_addr`.
- R3: With `order` = 0 (sequential), `cur_addr[1:0]` equals the captured low bits plus the beat number, modulo 4. Each advance therefore adds 1 to `cur_addr[1:0]`, modulo 4.
- R4: With `order` = 1 (interleaved), `cur_addr[1:0]` equals the captured low bits XOR the beat number.
- R5: At a rising edge with `ce_n` low and `adv_nld` high, the beat advances by one. The advance after `BEAT_3` wraps to `BEAT_0`, so the fifth address of a burst equals the first.
- R6: At a rising edge with `ce_n` high, the state does not change, whatever `adv_nld` and `base_addr` are. With `order` unchanged, `cur_addr` stays the same.
- R7: `cur_addr[AW-1:2]` never changes on an advance. It changes only on a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low clock enable; when high, all state is held |
| adv_nld | input | 1 | 0 = load a new base address, 1 = advance the beat |
| order | input | 1 | 0 = sequential (add) order, 1 = interleaved (XOR) order |
| base_addr | input | AW | Base address captured on a load |
| cur_addr | output | AW | Current access address |

## Verification
The assertions are evaluated on every cycle and cover four behaviours:
- the capture of a new base address;
- the hold when the clock enable is inactive;
- the fixed upper address bits during advances;
- the step size of one in sequential order.

A checker-side beat count also confirms the XOR relation in interleaved order. The bench scenarios cover the rest. They run all four starting offsets in both orders and follow each burst past its fourth beat to show the wrap. They also insert stalls in the middle of a burst, with a different address offered during the stall, to show that the sequence resumes where it stopped.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Number of words in one burst group and bits needed to index them.
    localparam int BEATS = 4;
    localparam int OFF_W = $clog2(BEATS);

    // Position inside the current burst.
    typedef enum logic [OFF_W-1:0] {
        BEAT_0 = 2'd0,
        BEAT_1 = 2'd1,
        BEAT_2 = 2'd2,
        BEAT_3 = 2'd3
    } beat_e;

    // Selection of the address order.
    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             do_load,
    output logic [OFF_W-1:0] beat_idx
);

    beat_e state_q;
    beat_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (step_en) begin
            if (do_load) begin
                state_d = BEAT_0;
            end else begin
                unique case (state_q)
                    BEAT_0:  state_d = BEAT_1;
                    BEAT_1:  state_d = BEAT_2;
                    BEAT_2:  state_d = BEAT_3;
                    BEAT_3:  state_d = BEAT_0;   // wrap within the group
                    default: state_d = BEAT_0;
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BEAT_0;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            BEAT_0:  beat_idx = 2'd0;
            BEAT_1:  beat_idx = 2'd1;
            BEAT_2:  beat_idx = 2'd2;
            BEAT_3:  beat_idx = 2'd3;
            default: beat_idx = 2'd0;
        endcase
    end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_seq_pkg::*;
(
    input  logic             ord,
    input  logic [OFF_W-1:0] base_lo,
    input  logic [OFF_W-1:0] beat_idx,
    output logic [OFF_W-1:0] addr_lo
);

    logic [OFF_W-1:0] seq_lo;
    logic [OFF_W-1:0] xor_lo;

    assign seq_lo = base_lo + beat_idx;   // modulo BEATS by width

    genvar gi;
    generate
        for (gi = 0; gi < OFF_W; gi++) begin : g_xor
            assign xor_lo[gi] = base_lo[gi] ^ beat_idx[gi];
        end
    endgenerate

    always_comb begin
        unique case (order_e'(ord))
            ORD_SEQ: addr_lo = seq_lo;
            ORD_XOR: addr_lo = xor_lo;
            default: addr_lo = seq_lo;
        endcase
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_nld,
    input  logic          order,
    input  logic [AW-1:0] base_addr,
    output logic [AW-1:0] cur_addr
);

    localparam int HI_W = AW - OFF_W;

    logic             step_en;
    logic             do_load;
    logic [AW-1:0]    base_q;
    logic [OFF_W-1:0] beat_idx;
    logic [OFF_W-1:0] addr_lo;

    assign step_en = !ce_n;
    assign do_load = !adv_nld;

    // Base address register, written only on a qualified load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (step_en && do_load) begin
            base_q <= base_addr;
        end
    end

    burst_beat_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .do_load  (do_load),
        .beat_idx (beat_idx)
    );

    burst_addr_map u_map (
        .ord      (order),
        .base_lo  (base_q[OFF_W-1:0]),
        .beat_idx (beat_idx),
        .addr_lo  (addr_lo)
    );

    assign cur_addr = {base_q[AW-1 -: HI_W], addr_lo};

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          adv_nld,
    input logic          order,
    input logic [AW-1:0] base_addr,
    input logic [AW-1:0] cur_addr
);

    // Checker-side record of the loaded low bits and beats since load.
    logic [1:0] ld_lo;
    logic [1:0] nbeat;
    logic       seen_ld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_lo   <= 2'd0;
            nbeat   <= 2'd0;
            seen_ld <= 1'b0;
        end else if (!ce_n) begin
            if (!adv_nld) begin
                ld_lo   <= base_addr[1:0];
                nbeat   <= 2'd0;
                seen_ld <= 1'b1;
            end else begin
                nbeat <= nbeat + 2'd1;
            end
        end
    end

    // R1: reset value
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (cur_addr == '0);
        end
    end

    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adv_nld) |=> cur_addr == $past(base_addr));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (order != $past(order)) || (cur_addr == $past(cur_addr)));

    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && adv_nld) |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]));

    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && adv_nld && !order) |=>
            order || (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    a_r4_xor_order: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_ld && order) |-> cur_addr[1:0] == (ld_lo ^ nbeat));

endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .adv_nld   (adv_nld),
    .order     (order),
    .base_addr (base_addr),
    .cur_addr  (cur_addr)
);

// File: tb/burst_seq_bench.sv
`timescale 1ns/1ps
module burst_seq_bench;

    localparam int AW = 32;

    typedef struct {
        logic [AW-1:0] exp;
        string         req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          adv_nld = 1'b1;
    logic          order = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] cur_addr;

    int n_chk = 0;
    int n_bad = 0;
    item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    burst_seq #(.AW(AW)) u_burst_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .adv_nld   (adv_nld),
        .order     (order),
        .base_addr (base_addr),
        .cur_addr  (cur_addr)
    );

    task automatic check(input logic [AW-1:0] got, input logic [AW-1:0] exp,
                         input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Driver: apply inputs for one edge and queue the address expected after it.
    task automatic step(input logic c, input logic a, input logic m,
                        input logic [AW-1:0] b, input logic [AW-1:0] exp,
                        input string req);
        item_t it;
        @(negedge clk);
        ce_n = c; adv_nld = a; order = m; base_addr = b;
        it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: sample 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(cur_addr, it.exp, it.req);
        end
    end

    function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] b,
                                               input logic m, input int k);
        logic [1:0] kk;
        kk = 2'(k % 4);
        return {b[AW-1:2], (m ? (b[1:0] ^ kk) : (b[1:0] + kk))};
    endfunction

    initial begin
        #10;
        check(cur_addr, '0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cur_addr, '0, "R1");
        for (int m = 0; m < 2; m++) begin
            for (int off = 0; off < 4; off++) begin
                logic [AW-1:0] b;
                string rq;
                b = {30'h1234_567 + 30'(off * 33 + m * 7), 2'(off)};
                rq = (m == 0) ? "R3" : "R4";
                step(1'b0, 1'b0, 1'(m), b, b, "R2");
                step(1'b0, 1'b1, 1'(m), ~b, ref_addr(b, 1'(m), 1), rq);
                step(1'b0, 1'b1, 1'(m), '0, ref_addr(b, 1'(m), 2), rq);
                // stall mid-burst: neither a load nor an advance may act
                step(1'b1, 1'b0, 1'(m), ~b, ref_addr(b, 1'(m), 2), "R6");
                step(1'b1, 1'b1, 1'(m), '1, ref_addr(b, 1'(m), 2), "R6");
                step(1'b0, 1'b1, 1'(m), '0, ref_addr(b, 1'(m), 3), "R7");
                step(1'b0, 1'b1, 1'(m), '0, ref_addr(b, 1'(m), 4), "R5");
                step(1'b0, 1'b1, 1'(m), '0, ref_addr(b, 1'(m), 5), "R5");
            end
        end
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule